// File: doc/BRIEF.md
# Double-Precision NaN Classifier and Quieter

This combinational unit inspects one 64-bit double-precision operand and reports its category: zero, subnormal, normal, infinity, quiet NaN or signalling NaN. A single mode input selects the polarity of the quiet indicator, which is the top fraction bit (bit 51). The mode is high for the 2008 convention and low for the legacy convention.

When the operand is a signalling NaN, the unit returns the quieted NaN and raises an invalid-operation flag. Any other operand is returned unchanged, with the flag low. An arithmetic pipeline uses the unit at its operand or result stage. The caller stores the flag and handles any trap.

Top module: `nanq_unit`

## Requirements
- R1: A non-NaN operand is classified by its exponent field (bits 62:52) and fraction (bits 51:0), using these class codes: 0 when the exponent and fraction are both zero, 1 when the exponent is zero and the fraction is nonzero, 2 when the exponent is neither zero nor 0x7FF, and 3 when the exponent is 0x7FF and the fraction is zero. The mode input has no effect on these codes.
- R2: An operand with exponent 0x7FF and a nonzero fraction is a NaN. It is signalling, with class code 5, when fraction bit 51 XOR the mode bit equals 1. Otherwise it is quiet, with class code 4.
- R3: With the mode high, a signalling NaN is quieted by setting fraction bit 51. All other fraction bits are kept.
- R4: With the mode low, a signalling NaN is quieted by clearing fraction bit 51. Bits 50:0 are kept when any of them is set.
- R5: With the mode low, a signalling NaN whose fraction bits 50:0 are all zero is quieted to a fraction with only bit 50 set, so the result stays a NaN and does not become an infinity.
- R6: The invalid flag is high exactly when the operand is classified as a signalling NaN.
- R7: The sign bit (63) and the exponent field of the result always equal those of the operand.
- R8: For every operand that is not a signalling NaN, the result equals the operand bit for bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand | input | 64 | Double-precision value to classify |
| mode2008 | input | 1 | 1: a clear bit 51 marks a signalling NaN; 0: a set bit 51 marks it |
| classCode | output | 3 | Class code as listed in R1 and R2 |
| result | output | 64 | Quieted NaN, or the operand unchanged |
| invalid | output | 1 | High when a signalling NaN was quieted |

## Verification
The in-RTL checks assume that the operand and the mode carry defined values. They are skipped while either input holds an unknown bit. The unit has no state, so the checks also assume that the outputs are only meaningful once the inputs have settled. The bench drives every input before its first sample and changes the inputs only at a clock edge, half a period before it samples the outputs. The stimulus covers signalling and quiet NaNs under both modes, including the legacy case with an empty lower fraction.

// File: rtl/nanq_pkg.sv
package nanq_pkg;
  localparam int WORD_W = 64;
  localparam int FRAC_W = 52;
  localparam int EXP_W  = 11;
  localparam int QBIT   = FRAC_W - 1;
  localparam int NBIT   = FRAC_W - 2;
  localparam int CLS_W  = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } cls_e;

  typedef struct packed {
    logic setQuiet;
    logic clearQuiet;
    logic setNext;
    logic raiseInvalid;
  } strobe_t;
endpackage

// File: rtl/nanq_ctrl.sv
module nanq_ctrl
  import nanq_pkg::*;
(
  input  logic [EXP_W-1:0]  expField,
  input  logic [FRAC_W-1:0] fracField,
  input  logic              mode2008,
  output logic [CLS_W-1:0]  classCode,
  output strobe_t           strobes
);
  logic expZero, expOnes, fracZero, lowerZero, isNan, isSig;

  always_comb begin
    expZero   = (expField == '0);
    expOnes   = (expField == '1);
    fracZero  = (fracField == '0);
    lowerZero = (fracField[QBIT-1:0] == '0);
    isNan     = expOnes && !fracZero;
    isSig     = isNan && (fracField[QBIT] ^ mode2008);
  end

  always_comb begin
    if (isNan)
      classCode = isSig ? CLS_SNAN : CLS_QNAN;
    else if (expOnes)
      classCode = CLS_INF;
    else if (expZero)
      classCode = fracZero ? CLS_ZERO : CLS_SUB;
    else
      classCode = CLS_NORM;
  end

  always_comb begin
    strobes.raiseInvalid = isSig;
    strobes.setQuiet     = isSig && mode2008;
    strobes.clearQuiet   = isSig && !mode2008;
    strobes.setNext      = isSig && !mode2008 && lowerZero;
  end

  always_comb begin
    if (!$isunknown({expField, fracField, mode2008})) begin
      assert_polarity_excl_R3: assert (!(strobes.setQuiet && strobes.clearQuiet))
        else $error("both quiet-bit strobes active");
      assert_next_legacy_R5: assert (!strobes.setNext || strobes.clearQuiet)
        else $error("fallback bit requested outside legacy quieting");
      assert_code_range_R1: assert (classCode <= CLS_SNAN)
        else $error("class code out of range");
    end
  end
endmodule

// File: rtl/nanq_dpath.sv
module nanq_dpath
  import nanq_pkg::*;
(
  input  logic [WORD_W-1:0] operand,
  input  strobe_t           strobes,
  output logic [WORD_W-1:0] result,
  output logic              invalid
);
  logic [FRAC_W-1:0] fracIn, fracOut;

  always_comb begin
    fracIn  = operand[FRAC_W-1:0];
    fracOut = fracIn;
    if (strobes.setQuiet)   fracOut[QBIT] = 1'b1;
    if (strobes.clearQuiet) fracOut[QBIT] = 1'b0;
    if (strobes.setNext)    fracOut[NBIT] = 1'b1;
    result  = {operand[WORD_W-1:FRAC_W], fracOut};
    invalid = strobes.raiseInvalid;
  end

  always_comb begin
    if (!$isunknown({operand, strobes})) begin
      assert_sign_exp_kept_R7: assert (result[WORD_W-1:FRAC_W] == operand[WORD_W-1:FRAC_W])
        else $error("sign or exponent altered");
      assert_fraction_nonzero_R5: assert (!invalid || result[FRAC_W-1:0] != '0)
        else $error("quieted value lost its NaN fraction");
    end
  end
endmodule

// File: rtl/nanq_unit.sv
module nanq_unit
  import nanq_pkg::*;
(
  input  logic [63:0] operand,
  input  logic        mode2008,
  output logic [2:0]  classCode,
  output logic [63:0] result,
  output logic        invalid
);
  strobe_t strobes;

  nanq_ctrl u_ctrl (
    .expField (operand[WORD_W-2:FRAC_W]),
    .fracField(operand[FRAC_W-1:0]),
    .mode2008 (mode2008),
    .classCode(classCode),
    .strobes  (strobes)
  );

  nanq_dpath u_dpath (
    .operand(operand),
    .strobes(strobes),
    .result (result),
    .invalid(invalid)
  );

  always_comb begin
    if (!$isunknown({operand, mode2008})) begin
      assert_invalid_iff_snan_R6: assert (invalid == (classCode == CLS_SNAN))
        else $error("invalid flag disagrees with class");
      assert_passthrough_R8: assert (classCode == CLS_SNAN || result == operand)
        else $error("non-signalling operand modified");
      assert_quieted_is_quiet_R2: assert (classCode != CLS_SNAN ||
                                          (result[QBIT] ^ mode2008) == 1'b0)
        else $error("quieted NaN still signalling");
    end
  end
endmodule

// File: tb/nanq_unit_tb.sv
module nanq_unit_tb;
  typedef struct packed {
    logic [63:0] op;
    logic        md;
    logic [2:0]  cls;
    logic [63:0] res;
    logic        inv;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{64'h0000000000000000, 1'b0, 3'd0, 64'h0000000000000000, 1'b0},
    '{64'h8000000000000000, 1'b1, 3'd0, 64'h8000000000000000, 1'b0},
    '{64'h0000000000000001, 1'b0, 3'd1, 64'h0000000000000001, 1'b0},
    '{64'h800FFFFFFFFFFFFF, 1'b1, 3'd1, 64'h800FFFFFFFFFFFFF, 1'b0},
    '{64'h3FF0000000000000, 1'b0, 3'd2, 64'h3FF0000000000000, 1'b0},
    '{64'hFFEFFFFFFFFFFFFF, 1'b1, 3'd2, 64'hFFEFFFFFFFFFFFFF, 1'b0},
    '{64'h7FF0000000000000, 1'b0, 3'd3, 64'h7FF0000000000000, 1'b0},
    '{64'hFFF0000000000000, 1'b1, 3'd3, 64'hFFF0000000000000, 1'b0},
    '{64'h7FF8000000000000, 1'b1, 3'd4, 64'h7FF8000000000000, 1'b0},
    '{64'h7FF0000000000001, 1'b1, 3'd5, 64'h7FF8000000000001, 1'b1},
    '{64'hFFF4000000000000, 1'b1, 3'd5, 64'hFFFC000000000000, 1'b1},
    '{64'h7FF0000000000001, 1'b0, 3'd4, 64'h7FF0000000000001, 1'b0},
    '{64'h7FF8000000000001, 1'b0, 3'd5, 64'h7FF0000000000001, 1'b1},
    '{64'h7FF8000000000000, 1'b0, 3'd5, 64'h7FF4000000000000, 1'b1},
    '{64'hFFF8000000000000, 1'b0, 3'd5, 64'hFFF4000000000000, 1'b1},
    '{64'h7FFFFFFFFFFFFFFF, 1'b0, 3'd5, 64'h7FF7FFFFFFFFFFFF, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [63:0] operand = '0;
  logic mode2008 = 1'b0;
  logic [2:0] classCode;
  logic [63:0] result;
  logic invalid;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nanq_unit u_dut (
    .operand(operand), .mode2008(mode2008),
    .classCode(classCode), .result(result), .invalid(invalid)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] op, input logic md);
    @(posedge clk);
    operand  = op;
    mode2008 = md;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset-state class", {61'd0, classCode}, 64'd0);
    check("R6 reset-state invalid", {63'd0, invalid}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].md);
      check(VECS[i].cls < 3'd4 ? "R1 class" : "R2 class", {61'd0, classCode}, {61'd0, VECS[i].cls});
      if (!VECS[i].inv)
        check("R8 passthrough", result, VECS[i].res);
      else if (VECS[i].md)
        check("R3 quiet 2008", result, VECS[i].res);
      else if (VECS[i].op[50:0] == '0)
        check("R5 legacy fallback", result, VECS[i].res);
      else
        check("R4 legacy quiet", result, VECS[i].res);
      check("R6 invalid", {63'd0, invalid}, {63'd0, VECS[i].inv});
      check("R7 sign/exponent", {52'd0, result[63:52]}, {52'd0, VECS[i].op[63:52]});
    end

    // R1: mode has no effect on a subnormal
    apply(64'h0008000000000000, 1'b1);
    check("R1 subnormal mode1", {61'd0, classCode}, 64'd1);
    check("R8 subnormal mode1", result, 64'h0008000000000000);
    apply(64'h0008000000000000, 1'b0);
    check("R1 subnormal mode0", {61'd0, classCode}, 64'd1);
    // R2: fraction only in bit 51 is quiet under 2008, signalling under legacy
    apply(64'h7FF8000000000000, 1'b1);
    check("R2 top-bit NaN mode1", {61'd0, classCode}, 64'd4);
    apply(64'h7FF8000000000000, 1'b0);
    check("R2 top-bit NaN mode0", {61'd0, classCode}, 64'd5);
    // R3: fraction only in bit 0 under 2008
    apply(64'hFFF0000000000001, 1'b1);
    check("R3 negative low-bit snan", result, 64'hFFF8000000000001);
    // R4: upper-bit-only tail kept under legacy
    apply(64'h7FFC000000000000, 1'b0);
    check("R4 bit50 tail kept", result, 64'h7FF4000000000000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule